// File: doc/BRIEF.md
# Dual-Pixel Raster Timing Generator

This block produces the raster timing for a 1600 x 1200 flat panel that takes two pixels on every clock, a first (even) pixel and a second (odd) pixel. It counts the line in pixel-pair clocks and the frame in lines. From those counts it drives horizontal sync, vertical sync and a display-enable strobe. It also gives an upstream pixel source the pair index and line index, plus the even and odd pixel positions of the current clock, so that source can fetch both RGB words in time.

Two timing presets are built in. Preset A is the long-blanking layout: 1080 clocks per line and 1250 lines per frame. Preset B is the reduced-blanking layout: 912 clocks per line and 1214 lines per frame. A select pin chooses the preset, and the new choice is only applied at a frame boundary. A second pin sets the sync polarity. The panel accepts either polarity, and active-high is the default, with the pin held at 0. There is no stream handshake here: the generator is the timing master, so the pixel source must follow it every clock and cannot apply back-pressure.

Top module: `pnl_timing_gen`

## Requirements
- R1: While `rst` is sampled high, every output is registered to its idle value: `de`, `frame_start` and `line_start` are 0, all indices are 0, and `hsync`/`vsync` sit at their inactive level, which equals `sync_neg`. The counters restart at line 0, pair 0. The first clock after release therefore shows `de`=1, `frame_start`=1 and pair 0 of line 0.
- R2: While `de` is 1, `even_pos` equals 2 x `pair_idx` and `odd_pos` equals 2 x `pair_idx` + 1, so pixels 0/1 come first and 1598/1599 come last. While `de` is 0, both are 0.
- R3: With preset A (`mode_sel`=0), each line lasts 1080 clocks in this order: 800 active, 32 front porch, 96 sync, 152 back porch.
- R4: With preset A, each frame lasts 1250 lines in this order: 1200 active, 1 front porch, 3 sync, 46 back porch. Vertical sync covers whole lines.
- R5: With preset B (`mode_sel`=1), each line lasts 912 clocks: 800 active, 48 front porch, 8 sync, 56 back porch.
- R6: With preset B, each frame lasts 1214 lines: 1200 active, 12 front porch, 1 sync, 1 back porch.
- R7: `de` is 1 exactly on the active clocks of active lines.
- R8: Each sync output equals its raw active flag XOR `sync_neg`. The value of `sync_neg` used is the one sampled at the same edge that updates the output, so `sync_neg`=0 gives active-high sync and 1 gives active-low sync.
- R9: A change of `mode_sel` takes effect only when the current frame wraps. The first clock that uses the new layout is the clock that carries `frame_start`. No line or frame is ever cut short.
- R10: While `de` is 1, `pair_idx` runs from 0 to 799 and `line_idx` from 0 to 1199. Both are 0 whenever `de` is 0.
- R11: `line_start` is high for one clock at the first clock of every line, blanking lines included. `frame_start` is high for one clock at pair 0 of line 0. All outputs lag the internal counters by exactly one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-pair clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | Preset select: 0 = A, 1 = B (applied at frame wrap) |
| sync_neg | input | 1 | Sync polarity: 0 = active high, 1 = active low |
| hsync | output | 1 | Horizontal sync, registered |
| vsync | output | 1 | Vertical sync, registered |
| de | output | 1 | Display enable, high on active pixels |
| pair_idx | output | PW (10) | Pixel-pair index within the line |
| line_idx | output | LW (11) | Active line index |
| even_pos | output | PW+1 (11) | Horizontal position of the even pixel |
| odd_pos | output | PW+1 (11) | Horizontal position of the odd pixel |
| frame_start | output | 1 | One-clock pulse at the first active pixel of a frame |
| line_start | output | 1 | One-clock pulse at the first clock of each line |

## Verification
The assertions assume that `mode_sel` is held still while `rst` is high, so the preset loaded during reset does not change on the release edge. They also assume reset is held for at least two clocks. The stimulus keeps to this by changing `mode_sel` and `sync_neg` only between clock edges and outside reset, and by raising reset for three clocks at a time. Apart from that, the polarity pin toggles at random instants, including in the middle of sync pulses. The preset pin toggles at random points within frames, which exercises the deferral to the frame wrap. A second, scaled instance has short porches so that whole frames in both presets fit inside the run.

// File: rtl/pnl_timing_pkg.sv
package pnl_timing_pkg;

  // Blanking layout of one axis; the active span is a module parameter.
  typedef struct packed {
    logic [15:0] fp;
    logic [15:0] sw;
    logic [15:0] bp;
  } axis_cfg_t;

  function automatic axis_cfg_t make_cfg(input int fp, input int sw, input int bp);
    axis_cfg_t c;
    c.fp = 16'(fp);
    c.sw = 16'(sw);
    c.bp = 16'(bp);
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pnl_axis_counter.sv
// One raster axis: counts active, front porch, sync, back porch, then wraps.
module pnl_axis_counter
  import pnl_timing_pkg::*;
#(
  parameter int CW  = 11,
  parameter int ACT = 800
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  axis_cfg_t     cfg,
  output logic [CW-1:0] cnt,
  output logic          in_act,
  output logic          in_sync,
  output logic          last
);

  logic [16:0] pos;
  logic [16:0] sync_lo;
  logic [16:0] sync_hi;
  logic [16:0] tot_m1;

  always_comb begin
    pos     = 17'(cnt);
    sync_lo = 17'(ACT) + 17'(cfg.fp);
    sync_hi = sync_lo + 17'(cfg.sw);
    tot_m1  = sync_hi + 17'(cfg.bp) - 17'd1;
    in_act  = pos < 17'(ACT);
    in_sync = (pos >= sync_lo) && (pos < sync_hi);
    last    = pos == tot_m1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (adv) begin
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pnl_preset_sel.sv
// Holds the preset in use; a new selection is loaded only at frame wrap.
module pnl_preset_sel
  import pnl_timing_pkg::*;
#(
  parameter int A_HFP = 32,
  parameter int A_HSW = 96,
  parameter int A_HBP = 152,
  parameter int A_VFP = 1,
  parameter int A_VSW = 3,
  parameter int A_VBP = 46,
  parameter int B_HFP = 48,
  parameter int B_HSW = 8,
  parameter int B_HBP = 56,
  parameter int B_VFP = 12,
  parameter int B_VSW = 1,
  parameter int B_VBP = 1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sel_in,
  input  logic      frame_end,
  output logic      mode_q,
  output axis_cfg_t h_cfg,
  output axis_cfg_t v_cfg
);

  localparam int NPRESET = 2;

  axis_cfg_t h_tab [NPRESET];
  axis_cfg_t v_tab [NPRESET];

  for (genvar p = 0; p < NPRESET; p++) begin : g_preset
    if (p == 0) begin : g_a
      assign h_tab[p] = make_cfg(A_HFP, A_HSW, A_HBP);
      assign v_tab[p] = make_cfg(A_VFP, A_VSW, A_VBP);
    end else begin : g_b
      assign h_tab[p] = make_cfg(B_HFP, B_HSW, B_HBP);
      assign v_tab[p] = make_cfg(B_VFP, B_VSW, B_VBP);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      mode_q <= sel_in;
    end
  end

  assign h_cfg = h_tab[mode_q];
  assign v_cfg = v_tab[mode_q];

endmodule

// File: rtl/pnl_out_stage.sv
// Registers every output from the current counter state.
module pnl_out_stage #(
  parameter int HW = 11,
  parameter int VW = 11,
  parameter int PW = 10,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_neg,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  logic          h_act,
  input  logic          v_act,
  input  logic          h_sync,
  input  logic          v_sync,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [PW-1:0] pair_idx,
  output logic [LW-1:0] line_idx,
  output logic [PW:0]   even_pos,
  output logic [PW:0]   odd_pos,
  output logic          frame_start,
  output logic          line_start
);

  logic          de_n;
  logic [PW-1:0] pair_n;
  logic [LW-1:0] line_n;
  logic          h_zero;
  logic          v_zero;

  always_comb begin
    de_n   = h_act && v_act;
    pair_n = de_n ? PW'(hcnt) : '0;
    line_n = de_n ? LW'(vcnt) : '0;
    h_zero = hcnt == '0;
    v_zero = vcnt == '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync       <= sync_neg;
      vsync       <= sync_neg;
      de          <= 1'b0;
      pair_idx    <= '0;
      line_idx    <= '0;
      even_pos    <= '0;
      odd_pos     <= '0;
      frame_start <= 1'b0;
      line_start  <= 1'b0;
    end else begin
      hsync       <= h_sync ^ sync_neg;
      vsync       <= v_sync ^ sync_neg;
      de          <= de_n;
      pair_idx    <= pair_n;
      line_idx    <= line_n;
      even_pos    <= de_n ? {pair_n, 1'b0} : '0;
      odd_pos     <= de_n ? {pair_n, 1'b1} : '0;
      frame_start <= h_zero && v_zero;
      line_start  <= h_zero;
    end
  end

endmodule

// File: rtl/pnl_timing_gen.sv
module pnl_timing_gen
  import pnl_timing_pkg::*;
#(
  parameter int H_ACT = 800,
  parameter int V_ACT = 1200,
  parameter int A_HFP = 32,
  parameter int A_HSW = 96,
  parameter int A_HBP = 152,
  parameter int A_VFP = 1,
  parameter int A_VSW = 3,
  parameter int A_VBP = 46,
  parameter int B_HFP = 48,
  parameter int B_HSW = 8,
  parameter int B_HBP = 56,
  parameter int B_VFP = 12,
  parameter int B_VSW = 1,
  parameter int B_VBP = 1,
  localparam int PW = $clog2(H_ACT),
  localparam int LW = $clog2(V_ACT),
  localparam int XW = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_sel,
  input  logic          sync_neg,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [PW-1:0] pair_idx,
  output logic [LW-1:0] line_idx,
  output logic [XW-1:0] even_pos,
  output logic [XW-1:0] odd_pos,
  output logic          frame_start,
  output logic          line_start
);

  localparam int HTOT_MAX = imax(H_ACT + A_HFP + A_HSW + A_HBP, H_ACT + B_HFP + B_HSW + B_HBP);
  localparam int VTOT_MAX = imax(V_ACT + A_VFP + A_VSW + A_VBP, V_ACT + B_VFP + B_VSW + B_VBP);
  localparam int HW = $clog2(HTOT_MAX);
  localparam int VW = $clog2(VTOT_MAX);

  logic          mode_q;
  axis_cfg_t     h_cfg;
  axis_cfg_t     v_cfg;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          h_act, h_sync, h_last;
  logic          v_act, v_sync, v_last;
  logic          frame_end;

  assign frame_end = h_last && v_last;

  pnl_preset_sel #(
    .A_HFP(A_HFP), .A_HSW(A_HSW), .A_HBP(A_HBP),
    .A_VFP(A_VFP), .A_VSW(A_VSW), .A_VBP(A_VBP),
    .B_HFP(B_HFP), .B_HSW(B_HSW), .B_HBP(B_HBP),
    .B_VFP(B_VFP), .B_VSW(B_VSW), .B_VBP(B_VBP)
  ) u_preset (
    .clk       (clk),
    .rst       (rst),
    .sel_in    (mode_sel),
    .frame_end (frame_end),
    .mode_q    (mode_q),
    .h_cfg     (h_cfg),
    .v_cfg     (v_cfg)
  );

  pnl_axis_counter #(.CW(HW), .ACT(H_ACT)) u_hcnt (
    .clk     (clk),
    .rst     (rst),
    .adv     (1'b1),
    .cfg     (h_cfg),
    .cnt     (hcnt),
    .in_act  (h_act),
    .in_sync (h_sync),
    .last    (h_last)
  );

  pnl_axis_counter #(.CW(VW), .ACT(V_ACT)) u_vcnt (
    .clk     (clk),
    .rst     (rst),
    .adv     (h_last),
    .cfg     (v_cfg),
    .cnt     (vcnt),
    .in_act  (v_act),
    .in_sync (v_sync),
    .last    (v_last)
  );

  pnl_out_stage #(.HW(HW), .VW(VW), .PW(PW), .LW(LW)) u_out (
    .clk         (clk),
    .rst         (rst),
    .sync_neg    (sync_neg),
    .hcnt        (hcnt),
    .vcnt        (vcnt),
    .h_act       (h_act),
    .v_act       (v_act),
    .h_sync      (h_sync),
    .v_sync      (v_sync),
    .hsync       (hsync),
    .vsync       (vsync),
    .de          (de),
    .pair_idx    (pair_idx),
    .line_idx    (line_idx),
    .even_pos    (even_pos),
    .odd_pos     (odd_pos),
    .frame_start (frame_start),
    .line_start  (line_start)
  );

endmodule

// File: rtl/pnl_timing_chk.sv
module pnl_timing_chk #(
  parameter int PW    = 10,
  parameter int LW    = 11,
  parameter int H_ACT = 800,
  parameter int V_ACT = 1200
) (
  input logic          clk,
  input logic          rst,
  input logic          sync_neg,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic [PW-1:0] pair_idx,
  input logic [LW-1:0] line_idx,
  input logic [PW:0]   even_pos,
  input logic [PW:0]   odd_pos,
  input logic          frame_start,
  input logic          line_start,
  input logic          mode_q
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!de && !frame_start && !line_start));

  // R2
  pixel_pos_chk: assert property (@(posedge clk) disable iff (rst)
    de |-> (even_pos == {pair_idx, 1'b0} && odd_pos == even_pos + 1'b1));

  // R10
  idle_index_chk: assert property (@(posedge clk) disable iff (rst)
    !de |-> (pair_idx == '0 && line_idx == '0 && even_pos == '0 && odd_pos == '0));

  // R10
  index_range_chk: assert property (@(posedge clk) disable iff (rst)
    de |-> (32'(pair_idx) < H_ACT && 32'(line_idx) < V_ACT));

  // R8
  hsync_idle_chk: assert property (@(posedge clk) disable iff (rst)
    de |-> (hsync == $past(sync_neg)));

  // R8
  vsync_idle_chk: assert property (@(posedge clk) disable iff (rst)
    de |-> (vsync == $past(sync_neg)));

  // R11
  frame_start_pos_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (line_start && de && pair_idx == '0 && line_idx == '0));

  // R11
  frame_start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  // R11
  line_start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !line_start);

  // R9
  mode_switch_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_q) |=> frame_start);

endmodule

bind pnl_timing_gen pnl_timing_chk #(
  .PW(PW), .LW(LW), .H_ACT(H_ACT), .V_ACT(V_ACT)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sync_neg    (sync_neg),
  .hsync       (hsync),
  .vsync       (vsync),
  .de          (de),
  .pair_idx    (pair_idx),
  .line_idx    (line_idx),
  .even_pos    (even_pos),
  .odd_pos     (odd_pos),
  .frame_start (frame_start),
  .line_start  (line_start),
  .mode_q      (mode_q)
);

// File: tb/tb_pnl_timing_gen.sv
module tb_pnl_timing_gen;

  // scaled instance geometry
  localparam int S_HACT = 8;
  localparam int S_VACT = 4;
  localparam int S_AHFP = 2, S_AHSW = 3, S_AHBP = 4;
  localparam int S_AVFP = 1, S_AVSW = 2, S_AVBP = 2;
  localparam int S_BHFP = 1, S_BHSW = 1, S_BHBP = 2;
  localparam int S_BVFP = 2, S_BVSW = 1, S_BVBP = 1;

  typedef struct {
    int h; int v; int mode;
  } mstate_t;

  typedef struct {
    int hact; int vact;
    int hfp[2]; int hsw[2]; int hbp[2];
    int vfp[2]; int vsw[2]; int vbp[2];
  } geom_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_sel = 1'b0;
  logic sync_neg = 1'b0;

  always #2 clk = ~clk;

  logic        d_hs, d_vs, d_de, d_fs, d_ls;
  logic [9:0]  d_pair;
  logic [10:0] d_line, d_ev, d_od;

  logic        s_hs, s_vs, s_de, s_fs, s_ls;
  logic [2:0]  s_pair;
  logic [1:0]  s_line;
  logic [3:0]  s_ev, s_od;

  pnl_timing_gen dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .sync_neg(sync_neg),
    .hsync(d_hs), .vsync(d_vs), .de(d_de), .pair_idx(d_pair), .line_idx(d_line),
    .even_pos(d_ev), .odd_pos(d_od), .frame_start(d_fs), .line_start(d_ls)
  );

  pnl_timing_gen #(
    .H_ACT(S_HACT), .V_ACT(S_VACT),
    .A_HFP(S_AHFP), .A_HSW(S_AHSW), .A_HBP(S_AHBP),
    .A_VFP(S_AVFP), .A_VSW(S_AVSW), .A_VBP(S_AVBP),
    .B_HFP(S_BHFP), .B_HSW(S_BHSW), .B_HBP(S_BHBP),
    .B_VFP(S_BVFP), .B_VSW(S_BVSW), .B_VBP(S_BVBP)
  ) dut_s (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .sync_neg(sync_neg),
    .hsync(s_hs), .vsync(s_vs), .de(s_de), .pair_idx(s_pair), .line_idx(s_line),
    .even_pos(s_ev), .odd_pos(s_od), .frame_start(s_fs), .line_start(s_ls)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  geom_t g_full, g_small;
  mstate_t m_full, m_small;
  bit sw_full, sw_small;

  task automatic cmp(input string name, input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, name, got, exp, $time);
    end
  endtask

  // Compare one instance's registered outputs against the model state that
  // the counters held before the latest edge, then advance the model.
  task automatic step(input string nm, input geom_t g, inout mstate_t m, inout bit sw,
                      input int got[9]);
    int e[9];
    int htot, vtot, hs_lo, vs_lo;
    bit act;
    string ht, vt;
    ht = (m.mode != 0) ? "R5/R8" : "R3/R8";
    vt = (m.mode != 0) ? "R6/R8" : "R4/R8";
    if (rst) begin
      e = '{0, sync_neg, sync_neg, 0, 0, 0, 0, 0, 0};
      ht = "R1"; vt = "R1";
    end else begin
      hs_lo = g.hact + g.hfp[m.mode];
      vs_lo = g.vact + g.vfp[m.mode];
      act   = (m.h < g.hact) && (m.v < g.vact);
      e[0] = act;
      e[1] = ((m.h >= hs_lo) && (m.h < hs_lo + g.hsw[m.mode])) ^ sync_neg;
      e[2] = ((m.v >= vs_lo) && (m.v < vs_lo + g.vsw[m.mode])) ^ sync_neg;
      e[3] = act ? m.h : 0;
      e[4] = act ? m.v : 0;
      e[5] = act ? 2 * m.h : 0;
      e[6] = act ? 2 * m.h + 1 : 0;
      e[7] = (m.h == 0) && (m.v == 0);
      e[8] = (m.h == 0);
    end
    cmp({nm, " de"},          rst ? "R1" : "R7",  got[0], e[0]);
    cmp({nm, " hsync"},       ht,                 got[1], e[1]);
    cmp({nm, " vsync"},       vt,                 got[2], e[2]);
    cmp({nm, " pair_idx"},    rst ? "R1" : "R10", got[3], e[3]);
    cmp({nm, " line_idx"},    rst ? "R1" : "R10", got[4], e[4]);
    cmp({nm, " even_pos"},    rst ? "R1" : "R2",  got[5], e[5]);
    cmp({nm, " odd_pos"},     rst ? "R1" : "R2",  got[6], e[6]);
    cmp({nm, " frame_start"}, rst ? "R1" : "R11", got[7], e[7]);
    cmp({nm, " line_start"},  rst ? "R1" : "R11", got[8], e[8]);
    // R9: a deferred preset change shows up with frame_start on this clock
    if (sw && !rst) cmp({nm, " frame_start after preset change"}, "R9", got[7], 1);
    sw = 0;
    if (rst) begin
      m.h = 0; m.v = 0; m.mode = mode_sel;
    end else begin
      htot = g.hact + g.hfp[m.mode] + g.hsw[m.mode] + g.hbp[m.mode];
      vtot = g.vact + g.vfp[m.mode] + g.vsw[m.mode] + g.vbp[m.mode];
      if (m.h == htot - 1) begin
        m.h = 0;
        if (m.v == vtot - 1) begin
          m.v = 0;
          if (m.mode != int'(mode_sel)) sw = 1;
          m.mode = mode_sel;
        end else begin
          m.v++;
        end
      end else begin
        m.h++;
      end
    end
  endtask

  task automatic cycle(input int p_sel, input int p_neg);
    int gf[9];
    int gs[9];
    @(posedge clk);
    #1;
    gf = '{d_de, d_hs, d_vs, d_pair, d_line, d_ev, d_od, d_fs, d_ls};
    gs = '{s_de, s_hs, s_vs, s_pair, s_line, s_ev, s_od, s_fs, s_ls};
    step("full",  g_full,  m_full,  sw_full,  gf);
    step("small", g_small, m_small, sw_small, gs);
    if (!rst) begin
      if (p_sel > 0 && ($urandom % p_sel) == 0) mode_sel = ~mode_sel;
      if (p_neg > 0 && ($urandom % p_neg) == 0) sync_neg = ~sync_neg;
    end
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    g_full  = '{hact: 800, vact: 1200,
                hfp: '{32, 48}, hsw: '{96, 8}, hbp: '{152, 56},
                vfp: '{1, 12},  vsw: '{3, 1},  vbp: '{46, 1}};
    g_small = '{hact: S_HACT, vact: S_VACT,
                hfp: '{S_AHFP, S_BHFP}, hsw: '{S_AHSW, S_BHSW}, hbp: '{S_AHBP, S_BHBP},
                vfp: '{S_AVFP, S_BVFP}, vsw: '{S_AVSW, S_BVSW}, vbp: '{S_AVBP, S_BVBP}};
    m_full  = '{0, 0, 0};
    m_small = '{0, 0, 0};
    sw_full = 0;
    sw_small = 0;

    // R1: reset with preset A, positive polarity
    rst = 1'b1; mode_sel = 1'b0; sync_neg = 1'b0;
    repeat (3) cycle(0, 0);
    rst = 1'b0;
    // R3, R7, R10, R11: preset A lines, polarity flips now and then (R8)
    repeat (3300) cycle(0, 400);

    // R1 with active-low polarity, then preset B from reset (R5)
    @(negedge clk);
    rst = 1'b1; mode_sel = 1'b1; sync_neg = 1'b1;
    repeat (3) cycle(0, 0);
    rst = 1'b0;
    repeat (2800) cycle(0, 400);

    // R4, R6, R9: random preset requests and polarity across many frames
    repeat (40000) cycle(250, 150);

    // mid-frame reset back to preset A
    @(negedge clk);
    rst = 1'b1; mode_sel = 1'b0;
    repeat (3) cycle(0, 0);
    rst = 1'b0;
    repeat (3000) cycle(0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule